// File: doc/BRIEF.md
# Five-Stage Logarithmic Shift and Rotate Unit

This block moves a data word left or right by 0 to 15 bit positions. Each move is either a shift, which fills vacated positions with zeros, or a rotate, in which bits that leave one end come back in at the other end. The datapath is a chain of five stages, sixteen cells each. Every cell is an AND-OR select of two candidate bits. The first stage moves data one place to the right or passes it through. The other four stages move data left by 1, 2, 4 and 8 places. A control decoder turns the 6-bit command into one pair of selects for every cell. A right move of n is built as a one-place right move followed by a left rotation of (1 - n) mod 16. When a right shift is requested, the first stage also clears the bits that would otherwise wrap around.

A phase input models a precharged datapath. While the phase input is low, every select is held low, so the whole array rests at zero. While it is high, the decoded selects are applied. A result register loads the array output on every clock edge that sees the evaluate phase. The last value loaded is kept once the phase drops, and a one-cycle valid strobe marks that moment.

Top module: `shift_rotate_unit`

## Requirements
- R1: With cmd[5]=0 (shift) and cmd[4]=0 (left), the evaluated output equals data_in shifted left by cmd[3:0] positions, with zeros entering at bit 0.
- R2: With cmd[5]=1 (rotate) and cmd[4]=0, the evaluated output equals data_in rotated left by cmd[3:0], so bit i moves to bit (i + n) mod 16.
- R3: With cmd[5]=0 and cmd[4]=1 (right), the evaluated output equals data_in logically shifted right by cmd[3:0], with zeros entering at bit 15.
- R4: With cmd[5]=1 and cmd[4]=1, the evaluated output equals data_in rotated right by cmd[3:0], so bit i moves to bit (i - n) mod 16.
- R5: An amount of zero passes data_in through unchanged, in both directions and both modes.
- R6: While eval_phase is low, array_out is all zeros, whatever data_in and cmd are.
- R7: An all-zero data_in gives an all-zero array_out in the evaluate phase, for every command.
- R8: result loads array_out on every rising clock edge at which eval_phase is high. It keeps its value at every edge at which eval_phase is low.
- R9: result_valid is high for exactly one cycle. That cycle follows the first rising edge that sees eval_phase low after an edge that saw it high.
- R10: In rotate mode the evaluated output has as many set bits as data_in. In shift mode it never has more.
- R11: A synchronous active-low reset clears result and result_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eval_phase | input | 1 | 1 = evaluate, 0 = precharge |
| cmd | input | 6 | [3:0] amount, [4] direction (1 = right), [5] mode (1 = rotate) |
| data_in | input | 16 | Word to move |
| array_out | output | 16 | Combinational output of the last array stage |
| result | output | 16 | Registered result |
| result_valid | output | 1 | One-cycle strobe after evaluate ends |

## Verification
array_out is combinational and must hold its expected value in the same cycle that the command is applied. The bench drives inputs on the falling edge and checks array_out shortly after, before the next rising edge. result holds the evaluated value from the first rising edge in evaluate. result_valid rises one edge after eval_phase is first seen low. The bench therefore checks the strobe and the captured word at the next falling edge, and one cycle later checks that the strobe has cleared and that result has held even though data_in was changed in between. The precharge check is made a short delay after eval_phase is lowered, before any clock edge.

// File: rtl/shr_pkg.sv
// Shared constants for the shift and rotate unit.
// Assumes the data width is a power of two.
package shr_pkg;
    localparam int DATA_W = 16;
endpackage

// File: rtl/shr_cell.sv
// One AND-OR select cell: q = (s0 & x) | (s1 & y).
// Assumes the control never raises both selects at once. Both low gives zero.
module shr_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic s0_i,
    input  logic s1_i,
    output logic q_o
);
    // Two-pair select
    assign q_o = (s0_i & x_i) | (s1_i & y_i);
endmodule

// File: rtl/shr_stage.sv
// One array stage of W cells. The x input of cell i is d[i].
// The y input comes from DIST places away: from above for a right stage,
// from below for a left stage, wrapping around the word ends.
module shr_stage #(
    parameter int W     = shr_pkg::DATA_W,
    parameter int DIST  = 1,
    parameter bit RIGHT = 1'b0
) (
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] s0_i,
    input  logic [W-1:0] s1_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_cell
        localparam int YI = RIGHT ? ((i + DIST) % W) : ((i + W - DIST) % W);
        shr_cell u_cell (
            .x_i  (d_i[i]),
            .y_i  (d_i[YI]),
            .s0_i (s0_i[i]),
            .s1_i (s1_i[i]),
            .q_o  (q_o[i])
        );
    end
endmodule

// File: rtl/shr_ctrl.sv
// Control decoder. It turns the command into one select pair per cell.
// Stage 0 is the right-by-one stage. Stage k (k >= 1) moves left by 2^(k-1).
// A right move of n > 0 is done as right-by-one, then a left rotate by
// (1 - n) mod W. For a right shift, stage 0 clears the bits that would wrap.
// All selects are low while eval_phase is low.
module shr_ctrl #(
    parameter int W    = shr_pkg::DATA_W,
    parameter int AW   = $clog2(W),
    parameter int NSTG = AW + 1
) (
    input  logic                      eval_phase,
    input  logic [AW+1:0]             cmd,
    output logic [NSTG-1:0][W-1:0]    sel0,
    output logic [NSTG-1:0][W-1:0]    sel1
);
    logic [AW-1:0] amt;
    logic          dir_r;
    logic          rot;
    logic          right_nz;
    logic [AW-1:0] lamt;

    // Split the command and work out the amount the left stages apply
    always_comb begin
        amt      = cmd[AW-1:0];
        dir_r    = cmd[AW];
        rot      = cmd[AW+1];
        right_nz = dir_r && (amt != '0);
        if (right_nz)
            lamt = AW'(1) - amt;
        else if (dir_r)
            lamt = '0;
        else
            lamt = amt;
    end

    // Per-cell select pairs; none are raised during precharge
    always_comb begin
        sel0 = '0;
        sel1 = '0;
        if (eval_phase) begin
            for (int i = 0; i < W; i++) begin
                if (right_nz)
                    sel1[0][i] = rot || ((i >= int'(amt) - 1) && (i <= W - 2));
                else
                    sel0[0][i] = 1'b1;
            end
            for (int k = 1; k < NSTG; k++) begin
                for (int i = 0; i < W; i++) begin
                    if (!lamt[k-1])
                        sel0[k][i] = 1'b1;
                    else
                        sel1[k][i] = (i >= (1 << (k - 1))) || rot || right_nz;
                end
            end
        end
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Top of the shift and rotate unit: control decoder, a five-stage select
// array and a result register. result loads on every edge in evaluate.
// result_valid strobes once after evaluate ends.
// Assumes that cmd and data_in are held steady during evaluate.
module shift_rotate_unit #(
    parameter int W    = shr_pkg::DATA_W,
    parameter int AW   = $clog2(W),
    parameter int NSTG = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval_phase,
    input  logic [AW+1:0] cmd,
    input  logic [W-1:0]  data_in,
    output logic [W-1:0]  array_out,
    output logic [W-1:0]  result,
    output logic          result_valid
);
    logic [NSTG-1:0][W-1:0] sel0;
    logic [NSTG-1:0][W-1:0] sel1;
    logic [W-1:0]           lvl [NSTG+1];
    logic [W-1:0]           result_q;
    logic                   valid_q;
    logic                   phase_q;

    shr_ctrl #(.W(W), .AW(AW), .NSTG(NSTG)) u_ctrl (
        .eval_phase (eval_phase),
        .cmd        (cmd),
        .sel0       (sel0),
        .sel1       (sel1)
    );

    assign lvl[0] = data_in;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        localparam int  DIST  = (g == 0) ? 1 : (1 << (g - 1));
        localparam bit  RIGHT = (g == 0);
        shr_stage #(.W(W), .DIST(DIST), .RIGHT(RIGHT)) u_stage (
            .d_i  (lvl[g]),
            .s0_i (sel0[g]),
            .s1_i (sel1[g]),
            .q_o  (lvl[g+1])
        );
    end

    assign array_out = lvl[NSTG];

    // Capture during evaluate, hold otherwise, strobe once evaluate ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
            phase_q  <= 1'b0;
        end else begin
            phase_q <= eval_phase;
            valid_q <= phase_q & ~eval_phase;
            if (eval_phase)
                result_q <= array_out;
        end
    end

    assign result       = result_q;
    assign result_valid = valid_q;
endmodule

// File: rtl/shr_checker.sv
// Property checker for shift_rotate_unit. It only observes the ports.
module shr_checker #(
    parameter int W  = shr_pkg::DATA_W,
    parameter int AW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eval_phase,
    input logic [AW+1:0] cmd,
    input logic [W-1:0]  data_in,
    input logic [W-1:0]  array_out,
    input logic [W-1:0]  result,
    input logic          result_valid
);
    assert_precharge_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_phase |-> array_out == '0);

    assert_zero_in_zero_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_phase && data_in == '0) |-> array_out == '0);

    assert_amount_zero_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_phase && cmd[AW-1:0] == '0) |-> array_out == data_in);

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eval_phase |=> result == $past(array_out));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_phase |=> $stable(result));

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_valid_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (!$past(eval_phase) && $past(eval_phase, 2)));

    assert_rotate_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_phase && cmd[AW+1]) |-> $countones(array_out) == $countones(data_in));

    assert_shift_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_phase && !cmd[AW+1]) |-> $countones(array_out) <= $countones(data_in));
endmodule

bind shift_rotate_unit shr_checker #(.W(W), .AW(AW)) u_shr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval_phase   (eval_phase),
    .cmd          (cmd),
    .data_in      (data_in),
    .array_out    (array_out),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_phase = 1'b0;
    logic [5:0]  cmd = '0;
    logic [15:0] data_in = '0;
    logic [15:0] array_out;
    logic [15:0] result;
    logic        result_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    shift_rotate_unit u_shift_rotate_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .eval_phase   (eval_phase),
        .cmd          (cmd),
        .data_in      (data_in),
        .array_out    (array_out),
        .result       (result),
        .result_valid (result_valid)
    );

    // Reference model written directly from R1 to R4
    function automatic logic [15:0] ref_op(logic [15:0] d, logic [5:0] c);
        logic [31:0] dd;
        int n;
        n  = int'(c[3:0]);
        dd = {d, d};
        if (!c[5] && !c[4]) return d << n;
        if (c[5]  && !c[4]) return 16'((dd << n) >> 16);
        if (!c[5] && c[4])  return d >> n;
        return 16'(dd >> n);
    endfunction

    function automatic string req_of(logic [15:0] d, logic [5:0] c);
        if (d == '0)       return "R7";
        if (c[3:0] == '0)  return "R5";
        if (c[5]) return c[4] ? "R4" : "R2";
        return c[4] ? "R3" : "R1";
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One operation: evaluate for one cycle, then precharge and watch capture
    task automatic run_op(logic [15:0] d, logic [5:0] c);
        logic [15:0] exp;
        exp = ref_op(d, c);
        @(negedge clk);
        data_in = d; cmd = c; eval_phase = 1'b1;
        #1 chk(req_of(d, c), array_out, exp);
        if (c[5]) chk("R10", 16'($countones(array_out)), 16'($countones(d)));
        @(negedge clk);
        eval_phase = 1'b0;
        #1 chk("R6", array_out, 16'h0000);
        @(negedge clk);
        chk("R9", {15'd0, result_valid}, 16'd1);
        chk("R8", result, exp);
        data_in = ~d; cmd = ~c;
        @(negedge clk);
        chk("R9", {15'd0, result_valid}, 16'd0);
        chk("R8", result, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11", result, 16'h0000);
        chk("R11", {15'd0, result_valid}, 16'd0);
        chk("R6", array_out, 16'h0000);
    endtask

    task automatic t_sweep(logic [15:0] d);
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 16; n++) begin
                run_op(d, {2'(m), 4'(n)});
            end
        end
    endtask

    task automatic t_precharge;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            data_in = 16'($urandom()) | 16'h8001; cmd = 6'($urandom()); eval_phase = 1'b0;
            #1 chk("R6", array_out, 16'h0000);
        end
    endtask

    task automatic t_long_eval;
        // Several evaluate cycles, data changing each cycle; result tracks last
        logic [15:0] d;
        d = 16'h0000;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            d = 16'h1357 + 16'(j * 16'h1111);
            data_in = d; cmd = 6'b01_0011; eval_phase = 1'b1;
        end
        @(negedge clk);
        chk("R8", result, ref_op(d, 6'b01_0011));
        chk("R9", {15'd0, result_valid}, 16'd0);
        eval_phase = 1'b0;
        @(negedge clk);
        chk("R9", {15'd0, result_valid}, 16'd1);
        chk("R8", result, ref_op(d, 6'b01_0011));
    endtask

    task automatic t_reset_mid;
        run_op(16'hBEEF, 6'b00_0001);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11", result, 16'h0000);
        chk("R11", {15'd0, result_valid}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sweep(16'h0000);
        t_sweep(16'hFFFF);
        t_sweep(16'h0001);
        t_sweep(16'h8000);
        t_sweep(16'hA5C3);
        t_sweep(16'($urandom()));
        t_precharge();
        t_long_eval();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule